// File: doc/BRIEF.md
# Multiplexed 4:2:2 Component Stream Splitter

This block takes one multiplexed component video stream and turns it into parallel luma, blue-difference and red-difference words at the pixel rate. The stream runs at twice the pixel rate and repeats the order Cb, Y, Cr, Y. The Y that comes straight after a Cb shares its position on the line with that Cb and with the Cr that follows. The second Y of the group has no chroma of its own.

Each group of four samples produces two output pixels, one every second sample clock. Both pixels carry the chroma pair of the group. A flag marks the pixel whose Y is co-sited with that chroma.

Word alignment depends on the synchronisation mode. In embedded mode, timing reference codes inside the stream set the alignment and also gate the active region. In slave and genlock modes, the falling edge of an external active-low horizontal sync sets it. In master mode, the falling edge of a horizontal sync that the surrounding chip generates sets it.

Top module: `yc422_splitter`

## Requirements
- R1: While reset is high, and after reset until the first alignment event, `out_valid` stays low. After reset, `y_out`, `cb_out`, `cr_out` and `out_cosited` are zero.
- R2: Within a group, samples are taken in the order Cb, Y0, Cr, Y1. Each complete group yields two pixels in this order: (Y0, Cb, Cr) with `out_cosited`=1, then (Y1, Cb, Cr) with `out_cosited`=0.
- R3: `out_valid` is high for one cycle per pixel. The Y0 pixel appears on the edge after the Cr sample is clocked in. The Y1 pixel appears exactly two edges later, so pixels within a line are two sample clocks apart.
- R4: In embedded mode (`sync_mode`=00), a timing reference code is the word sequence 3FF, 000, 000, XY. XY has bit 9 set, and bit 6 of XY is the H flag. H=0 marks start of active video, and the sample right after XY is taken as Cb.
- R5: In embedded mode, a 3FF word ends active data. The reference code words, an XY with H=1 (end of active video), and every sample up to the next start code produce no output.
- R6: In slave (01) and genlock (11) modes, the first sample clocked in while `ext_hs_n` is low, after having been high, is discarded. The next sample is taken as Cb. `int_hs_n` has no effect in these modes.
- R7: In master mode (10), the sample clocked in on the falling edge of `int_hs_n` is discarded. The next sample is taken as a Y that completes no group, and the one after it is taken as Cb. `ext_hs_n` has no effect in this mode.
- R8: Every alignment event restarts the sample phase, whatever phase the stream had before. A group that a non-data sample interrupts yields no pixel for its incomplete part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 2 | 00 embedded, 01 slave, 10 master, 11 genlock |
| pix_in | input | DW (10) | Multiplexed Cb/Y/Cr/Y sample word |
| ext_hs_n | input | 1 | External horizontal sync, active low |
| int_hs_n | input | 1 | Internally generated horizontal sync, active low |
| y_out | output | DW (10) | Luma of the emitted pixel |
| cb_out | output | DW (10) | Blue-difference word of the emitted pixel |
| cr_out | output | DW (10) | Red-difference word of the emitted pixel |
| out_valid | output | 1 | One-cycle strobe per emitted pixel |
| out_cosited | output | 1 | High when the emitted Y is co-sited with its chroma |

## Verification
The bench varies the blanking length before each start code and runs several lines back to back without a reset, so the phase before each code is different every time. A splitter that kept its old phase would swap luma and chroma, and one that took the XY word as data would emit one pixel too many. The slave, genlock and master cases each vary the number of junk samples before the sync edge, and they toggle the sync input that the mode should ignore. A design that took the wrong sync, or that treated the sample after a master edge as Cb rather than Y, would shift every component by one or more places. The co-siting flag, the shared chroma of the second pixel and the two-clock spacing are compared pixel by pixel. Together these expose a swapped flag, a chroma register that is not held, and a strobe that is emitted early.

// File: rtl/yc422_pkg.sv
package yc422_pkg;

  typedef enum logic [1:0] {
    SM_EMBED   = 2'b00,
    SM_SLAVE   = 2'b01,
    SM_MASTER  = 2'b10,
    SM_GENLOCK = 2'b11
  } sync_mode_e;

  // position of a sample inside the Cb, Y0, Cr, Y1 group
  localparam logic [1:0] PH_CB = 2'd0;
  localparam logic [1:0] PH_Y0 = 2'd1;
  localparam logic [1:0] PH_CR = 2'd2;
  localparam logic [1:0] PH_Y1 = 2'd3;

endpackage

// File: rtl/trs_detector.sv
module trs_detector #(
  parameter int DW   = 10,
  parameter int HBIT = DW - 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pix,
  output logic          sav_hit,
  output logic          eav_hit
);

  // three-word history: h2 oldest
  logic [DW-1:0] h0, h1, h2;
  logic          code_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      h0 <= '0;
      h1 <= '0;
      h2 <= '0;
    end else begin
      h2 <= h1;
      h1 <= h0;
      h0 <= pix;
    end
  end

  // the current word is the XY word of a reference code
  always_comb begin
    code_seen = (h2 == '1) && (h1 == '0) && (h0 == '0) && pix[DW-1];
    sav_hit   = code_seen && !pix[HBIT];
    eav_hit   = code_seen &&  pix[HBIT];
  end

endmodule

// File: rtl/hsync_edge.sv
module hsync_edge
  import yc422_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sync_mode_e mode,
  input  logic       ext_hs_n,
  input  logic       int_hs_n,
  output logic       hs_fall
);

  logic hs_sel;
  logic hs_prev;

  // master mode follows the internal sync, slave and genlock the external one
  always_comb hs_sel = (mode == SM_MASTER) ? int_hs_n : ext_hs_n;

  always_ff @(posedge clk) begin
    if (rst) hs_prev <= 1'b1;
    else     hs_prev <= hs_sel;
  end

  always_comb hs_fall = (mode != SM_EMBED) && hs_prev && !hs_sel;

endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import yc422_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sync_mode_e mode,
  input  logic       sav_hit,
  input  logic       eav_hit,
  input  logic       ctrl_word,
  input  logic       hs_fall,
  output logic [1:0] phase_q,
  output logic       data_ok
);

  logic embed, master, align_evt, act_q;

  always_comb begin
    embed     = (mode == SM_EMBED);
    master    = (mode == SM_MASTER);
    align_evt = embed ? sav_hit : hs_fall;
    data_ok   = embed ? (act_q && !ctrl_word) : (act_q && !hs_fall);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CB;
      act_q   <= 1'b0;
    end else begin
      if (align_evt) phase_q <= master ? PH_Y1 : PH_CB;
      else           phase_q <= phase_q + 2'd1;

      if (embed) begin
        if (sav_hit)                 act_q <= 1'b1;
        else if (ctrl_word || eav_hit) act_q <= 1'b0;
      end else if (hs_fall) begin
        act_q <= 1'b1;
      end
    end
  end

  // R4: the word after a start code is a Cb of active data
  a_r4_cb_after_sav: assert property (@(posedge clk) disable iff (rst)
    (embed && sav_hit) |=> (phase_q == PH_CB) && act_q);

  // R6: slave and genlock edges put the next sample on Cb
  a_r6_slave_cb: assert property (@(posedge clk) disable iff (rst)
    (!embed && !master && hs_fall) |=> (phase_q == PH_CB));

  // R7: master edges put the next sample on a Y
  a_r7_master_y: assert property (@(posedge clk) disable iff (rst)
    (master && hs_fall) |=> (phase_q == PH_Y1));

endmodule

// File: rtl/group_asm.sv
module group_asm
  import yc422_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pix,
  input  logic [1:0]    phase,
  input  logic          data_ok,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] cb_out,
  output logic [DW-1:0] cr_out,
  output logic          out_valid,
  output logic          out_cosited
);

  logic [DW-1:0] cb_h, y0_h, cr_h, y1_h;
  logic [1:0]    fill;   // consecutive data samples of the current group
  logic          pend1;  // second pixel waiting for its slot

  always_ff @(posedge clk) begin
    if (rst) begin
      cb_h        <= '0;
      y0_h        <= '0;
      cr_h        <= '0;
      y1_h        <= '0;
      fill        <= 2'd0;
      pend1       <= 1'b0;
      y_out       <= '0;
      cb_out      <= '0;
      cr_out      <= '0;
      out_valid   <= 1'b0;
      out_cosited <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (pend1) begin
        y_out       <= y1_h;
        cb_out      <= cb_h;
        cr_out      <= cr_h;
        out_valid   <= 1'b1;
        out_cosited <= 1'b0;
        pend1       <= 1'b0;
      end
      if (!data_ok) begin
        fill <= 2'd0;
      end else begin
        case (phase)
          PH_CB: begin
            cb_h <= pix;
            fill <= 2'd1;
          end
          PH_Y0: begin
            y0_h <= pix;
            fill <= (fill == 2'd1) ? 2'd2 : 2'd0;
          end
          PH_CR: begin
            if (fill == 2'd2) begin
              cr_h        <= pix;
              y_out       <= y0_h;
              cb_out      <= cb_h;
              cr_out      <= pix;
              out_valid   <= 1'b1;
              out_cosited <= 1'b1;
              fill        <= 2'd3;
            end else begin
              fill <= 2'd0;
            end
          end
          default: begin
            if (fill == 2'd3) begin
              y1_h  <= pix;
              pend1 <= 1'b1;
            end
            fill <= 2'd0;
          end
        endcase
      end
    end
  end

  // R3: a strobe never lasts two cycles
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2: the second pixel repeats the chroma of the first
  a_r2_chroma_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_cosited) |-> ($stable(cb_out) && $stable(cr_out)));

  // R2: a non-co-sited pixel comes two cycles after a co-sited one
  a_r2_pair_order: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_cosited) |-> ($past(out_valid, 2) && $past(out_cosited, 2)));

  // R5: a co-sited pixel only follows a data sample
  a_r5_no_emit_nondata: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cosited) |-> $past(data_ok));

endmodule

// File: rtl/yc422_splitter.sv
module yc422_splitter
  import yc422_pkg::*;
#(
  parameter int DW   = 10,
  parameter int HBIT = DW - 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    sync_mode,
  input  logic [DW-1:0] pix_in,
  input  logic          ext_hs_n,
  input  logic          int_hs_n,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] cb_out,
  output logic [DW-1:0] cr_out,
  output logic          out_valid,
  output logic          out_cosited
);

  sync_mode_e mode;
  logic       sav_hit, eav_hit, ctrl_word, hs_fall, data_ok;
  logic [1:0] phase;

  always_comb begin
    mode      = sync_mode_e'(sync_mode);
    ctrl_word = (pix_in == '1);
  end

  trs_detector #(.DW(DW), .HBIT(HBIT)) u_trs (
    .clk     (clk),
    .rst     (rst),
    .pix     (pix_in),
    .sav_hit (sav_hit),
    .eav_hit (eav_hit)
  );

  hsync_edge u_hs (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .ext_hs_n (ext_hs_n),
    .int_hs_n (int_hs_n),
    .hs_fall  (hs_fall)
  );

  phase_seq u_phase (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .sav_hit   (sav_hit),
    .eav_hit   (eav_hit),
    .ctrl_word (ctrl_word),
    .hs_fall   (hs_fall),
    .phase_q   (phase),
    .data_ok   (data_ok)
  );

  group_asm #(.DW(DW)) u_grp (
    .clk         (clk),
    .rst         (rst),
    .pix         (pix_in),
    .phase       (phase),
    .data_ok     (data_ok),
    .y_out       (y_out),
    .cb_out      (cb_out),
    .cr_out      (cr_out),
    .out_valid   (out_valid),
    .out_cosited (out_cosited)
  );

  // R1: no strobe while reset is held
  a_r1_quiet_reset: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/yc422_splitter_test.sv
module yc422_splitter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [9:0] pix = '0;
  logic       ext = 1'b1;
  logic       intl = 1'b1;
  logic [9:0] y_out, cb_out, cr_out;
  logic       out_valid, out_cosited;

  int nchk = 0;
  int nfail = 0;
  bit rec_en = 1'b0;
  int n_got = 0;
  int cyc = 0;
  int got_y[128], got_cb[128], got_cr[128], got_cos[128], got_t[128];

  always #5 clk = ~clk;

  yc422_splitter uut (
    .clk(clk), .rst(rst), .sync_mode(mode), .pix_in(pix),
    .ext_hs_n(ext), .int_hs_n(intl),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out),
    .out_valid(out_valid), .out_cosited(out_cosited)
  );

  always @(negedge clk) begin
    cyc++;
    if (rec_en && out_valid && n_got < 128) begin
      got_y[n_got]   = int'(y_out);
      got_cb[n_got]  = int'(cb_out);
      got_cr[n_got]  = int'(cr_out);
      got_cos[n_got] = int'(out_cosited);
      got_t[n_got]   = cyc;
      n_got++;
    end
  end

  function automatic int fcb(int g); return 100 + g; endfunction
  function automatic int fy0(int g); return 300 + 2 * g; endfunction
  function automatic int fy1(int g); return 301 + 2 * g; endfunction
  function automatic int fcr(int g); return 600 + g; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic send(input int v);
    @(posedge clk); #2;
    pix = 10'(v);
  endtask

  task automatic send_hs(input int v, input logic e, input logic i);
    @(posedge clk); #2;
    pix = 10'(v); ext = e; intl = i;
  endtask

  task automatic send_groups(input int g0, input int n);
    for (int g = g0; g < g0 + n; g++) begin
      send(fcb(g)); send(fy0(g)); send(fcr(g)); send(fy1(g));
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(posedge clk); #2;
    rst = 1'b1; mode = m; ext = 1'b1; intl = 1'b1; pix = 10'h040;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    chk(!out_valid && y_out == 0 && cb_out == 0 && cr_out == 0 && !out_cosited,
        "R1 reset state", int'(out_valid), 0);
    @(posedge clk); #2;
    rst = 1'b0;
    n_got = 0;
    rec_en = 1'b1;
  endtask

  task automatic finish_run();
    @(negedge clk); #1;
    rec_en = 1'b0;
  endtask

  task automatic check_run(input int base, input int g0, input int n, input string tag);
    for (int k = 0; k < 2 * n; k++) begin
      int idx = base + k;
      int g = g0 + k / 2;
      int cos = (k % 2 == 0) ? 1 : 0;
      int ey = (cos == 1) ? fy0(g) : fy1(g);
      chk(got_y[idx] == ey, {tag, " R2 luma"}, got_y[idx], ey);
      chk(got_cb[idx] == fcb(g) && got_cr[idx] == fcr(g), {tag, " R2 chroma"},
          got_cb[idx] * 1000 + got_cr[idx], fcb(g) * 1000 + fcr(g));
      chk(got_cos[idx] == cos, {tag, " R2 cosite flag"}, got_cos[idx], cos);
      if (k > 0)
        chk(got_t[idx] - got_t[idx-1] == 2, {tag, " R3 spacing"},
            got_t[idx] - got_t[idx-1], 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int g;
    int base;
    // ---- embedded mode: several lines, blanking length varied (R4 R5 R8)
    do_reset(2'b00);
    g = 0;
    for (int l = 0; l < 6; l++) begin
      for (int b = 0; b < l + 1; b++) send((b % 2 == 0) ? 10'h040 : 10'h200);
      send(10'h3FF); send(0); send(0); send(10'h200);   // start code, H=0
      send_groups(g, l + 2);
      send(10'h3FF); send(0); send(0); send(10'h240);   // end code, H=1
      g = g + l + 2;
    end
    repeat (6) send(10'h200);
    finish_run();
    // R5: nothing emitted from codes or blanking
    chk(n_got == 54, "R5 pixel count over embedded lines", n_got, 54);
    base = 0; g = 0;
    for (int l = 0; l < 6; l++) begin
      check_run(base, g, l + 2, "R4 R8 embedded");
      base = base + 2 * (l + 2);
      g = g + l + 2;
    end

    // ---- slave and genlock modes (R6 R8 R1)
    for (int md = 1; md <= 3; md += 2) begin
      for (int o = 0; o < 4; o++) begin
        do_reset(2'(md));
        for (int k = 0; k < o; k++) send_hs(50 + k, 1'b1, k[0]);  // internal sync toggles, ignored
        send_hs(10'h055, 1'b0, 1'b1);
        send_groups(0, 3);
        send(10'h040); send(10'h200);
        finish_run();
        chk(n_got == 6, "R6 R1 slave pixel count", n_got, 6);
        if (n_got == 6) check_run(0, 0, 3, "R6 slave");
      end
    end

    // ---- master mode (R7 R8)
    for (int o = 0; o < 4; o++) begin
      do_reset(2'b10);
      for (int k = 0; k < o; k++) send_hs(60 + k, k[0], 1'b1);  // external sync toggles, ignored
      send_hs(10'h066, 1'b0, 1'b0);
      send(10'h077);                  // Y that completes no group
      send_groups(0, 3);
      send(10'h040); send(10'h200);
      finish_run();
      chk(n_got == 6, "R7 master pixel count", n_got, 6);
      if (n_got == 6) check_run(0, 0, 3, "R7 master");
    end

    summary();
    $finish;
  end

endmodule